// File: doc/BRIEF.md
# External Interrupt Edge Capture Controller

This block sits on a digital input card and turns a transition driven by an external user circuit into a level interrupt for the host. A control enable repurposes two pins of the last port group. Bit 6 of that group becomes the interrupt request input. Bit 7 becomes an active-low gate input. While the gate is held low, the block watches the request for a selected transition. The transition can be the rising edge, the falling edge or either edge. When the selected transition arrives, the block raises a sticky pending flag. That flag drives the host interrupt line directly.

Each port group has two controls of its own: a hold-enable bit and a capture-edge bit. A group with hold enabled returns the data it sampled on its own chosen transition of the request. Any other group returns its pins unchanged. While the pending flag is set, request transitions are dropped. They do not queue, and they do not update any group. The host clears the flag with a one-cycle write-one pulse. The request and gate pins pass through a two-flop synchronizer, and the group data passes through a matching synchronizer so that both stay aligned.

Top module: `ext_irq_capture`

## Requirements
- R1: After reset, pend_o and irq_o are 0 and every group's held data is 0, so a group with hold enabled reads 0.
- R2: While irq_en_i is 0, request transitions never set pend_o and never update held data, and port_o bits 30 and 31 read the pins like any other bit.
- R3: While irq_en_i is 1, port_i bit 30 (group 3 bit 6) is the request and port_i bit 31 (group 3 bit 7) is the active-low gate, and port_o bits 30 and 31 read 0.
- R4: While the gate pin is 1, request transitions neither set pend_o nor update held data.
- R5: With irq_both_i at 0, irq_edge_i at 0 selects the rising edge of the request for the host interrupt and irq_edge_i at 1 selects the falling edge; the other edge leaves pend_o at 0.
- R6: With irq_both_i at 1, either edge of the request sets pend_o, whatever the value of irq_edge_i.
- R7: An accepted transition on the request pin, driven before clock edge k, shows on pend_o after clock edge k+2, and irq_o always equals pend_o.
- R8: While pend_o is 1, it stays 1 unless it is cleared, and request transitions, including the opposite edge in both-edges mode, update no held data.
- R9: A one-cycle pend_clr_i pulse clears pend_o on the next edge; if a selected transition is detected on that same edge, pend_o stays 1.
- R10: Driving irq_en_i to 0 clears pend_o on the next clock edge.
- R11: Bit g of grp_latch_en_i set to 1 makes group g (port bits 8g+7..8g) read its held data; set to 0, the group reads its pins. A group captures its synchronized pin data on a transition selected by bit g of grp_edge_i (0 rising, 1 falling), and only when that transition arrives with the enable on, the gate low and pend_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Interrupt enable; repurposes group 3 bits 6 and 7 |
| irq_edge_i | input | 1 | Host interrupt edge: 0 rising, 1 falling |
| irq_both_i | input | 1 | 1: either edge sets the pending flag |
| grp_latch_en_i | input | 4 | Per-group hold enable |
| grp_edge_i | input | 4 | Per-group capture edge: 0 rising, 1 falling |
| pend_clr_i | input | 1 | Write-one pulse that clears the pending flag |
| port_i | input | 32 | Input pins, 8 bits per group, group 0 lowest |
| port_o | output | 32 | Read data per group |
| pend_o | output | 1 | Sticky pending flag |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench sweeps every combination of host edge select, both-edges mode, transition direction and gate level. Across that sweep it also walks all sixteen per-group capture-edge codes, under two patterns of hold enable. This separates a wrong polarity decode from a missing gate qualification, and it shows whether a group captures on the host's edge or on its own. Wherever a vector sets the flag, the bench then drives the opposite edge to show that the edge is dropped. Directed sequences cover the disabled state, a clear that collides with a new transition, and a clear caused by turning the enable off.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  function automatic logic edge_hit(input logic rise, input logic fall, input edge_sel_e sel);
    return (sel == EDGE_FALL) ? fall : rise;
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> stg_q[1] == $past(stg_q[0])); // R7
    end
  endgenerate
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R5
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R5
endmodule

// File: rtl/eic_grp_latch.sv
module eic_grp_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] data_s_i,
  input  logic         latch_en_i,
  input  logic         cap_i,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= data_s_i;
  end

  assign rd_o = latch_en_i ? hold_q : pin_i;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && !cap_i) ##1 latch_en_i |-> $stable(rd_o)); // R11
endmodule

// File: rtl/eic_pend.sv
module eic_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic gate_low_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic set_w;

  assign set_w = en_i & gate_low_i & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (!en_i) pend_q <= 1'b0;
    else            pend_q <= set_w | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i && en_i |=> pend_q); // R8
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q); // R10
  AST_GATE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !gate_low_i |=> !pend_q); // R4
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && clr_i && !hit_i |=> !pend_q); // R9
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture #(
  parameter int unsigned NUM_GROUPS  = 4,
  parameter int unsigned GROUP_W     = 8,
  parameter int unsigned REQ_BIT     = 6,
  parameter int unsigned GATE_BIT    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          irq_en_i,
  input  logic                          irq_edge_i,
  input  logic                          irq_both_i,
  input  logic [NUM_GROUPS-1:0]         grp_latch_en_i,
  input  logic [NUM_GROUPS-1:0]         grp_edge_i,
  input  logic                          pend_clr_i,
  input  logic [NUM_GROUPS*GROUP_W-1:0] port_i,
  output logic [NUM_GROUPS*GROUP_W-1:0] port_o,
  output logic                          pend_o,
  output logic                          irq_o
);
  import eic_pkg::*;

  localparam int unsigned PW       = NUM_GROUPS * GROUP_W;
  localparam int unsigned REQ_IDX  = (NUM_GROUPS - 1) * GROUP_W + REQ_BIT;
  localparam int unsigned GATE_IDX = (NUM_GROUPS - 1) * GROUP_W + GATE_BIT;

  logic [1:0]    ctl_s;
  logic          req_s, gate_s, gate_low;
  logic [PW-1:0] data_s, rd_all;
  logic          rise, fall, host_hit, accept, pend;

  // gate resets high so nothing is qualified out of reset
  eic_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_ctl_sync (
    .clk_i, .rst_ni,
    .d_i ({port_i[GATE_IDX], port_i[REQ_IDX]}),
    .q_o (ctl_s)
  );
  assign req_s    = ctl_s[0];
  assign gate_s   = ctl_s[1];
  assign gate_low = ~gate_s;

  eic_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk_i, .rst_ni, .d_i(port_i), .q_o(data_s)
  );

  eic_edge_det u_edge (
    .clk_i, .rst_ni, .sig_i(req_s), .rise_o(rise), .fall_o(fall)
  );

  assign host_hit = irq_both_i ? (rise | fall) : edge_hit(rise, fall, edge_sel_e'(irq_edge_i));
  assign accept   = irq_en_i & gate_low & ~pend;

  eic_pend u_pend (
    .clk_i, .rst_ni,
    .en_i      (irq_en_i),
    .gate_low_i(gate_low),
    .hit_i     (host_hit),
    .clr_i     (pend_clr_i),
    .pend_o    (pend)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic cap;
    assign cap = accept & edge_hit(rise, fall, edge_sel_e'(grp_edge_i[g]));
    eic_grp_latch #(.W(GROUP_W)) u_latch (
      .clk_i, .rst_ni,
      .pin_i     (port_i[g*GROUP_W +: GROUP_W]),
      .data_s_i  (data_s[g*GROUP_W +: GROUP_W]),
      .latch_en_i(grp_latch_en_i[g]),
      .cap_i     (cap),
      .rd_o      (rd_all[g*GROUP_W +: GROUP_W])
    );
  end

  always_comb begin
    port_o = rd_all;
    if (irq_en_i) begin
      port_o[REQ_IDX]  = 1'b0;
      port_o[GATE_IDX] = 1'b0;
    end
  end

  assign pend_o = pend;
  assign irq_o  = pend;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i)); // R2
  AST_PINS_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i |-> (port_o[REQ_IDX] == 1'b0) && (port_o[GATE_IDX] == 1'b0)); // R3
endmodule

// File: tb/sim_ext_irq_capture.sv
`timescale 1ns/1ps
module sim_ext_irq_capture;
  localparam int NG = 4;
  localparam int GW = 8;
  localparam int PW = NG * GW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_en = 1'b0, irq_edge = 1'b0, irq_both = 1'b0, pend_clr = 1'b0;
  logic [NG-1:0] lat_en = '0, grp_edge = '0;
  logic [PW-1:0] port_in = '0;
  logic [PW-1:0] port_out;
  logic          pend, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [GW-1:0] hold_m [NG];

  always #2.5 clk = ~clk;

  ext_irq_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_en_i(irq_en), .irq_edge_i(irq_edge),
    .irq_both_i(irq_both), .grp_latch_en_i(lat_en), .grp_edge_i(grp_edge),
    .pend_clr_i(pend_clr), .port_i(port_in), .port_o(port_out),
    .pend_o(pend), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_port();
    logic [PW-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g*GW +: GW] = lat_en[g] ? hold_m[g] : port_in[g*GW +: GW];
    if (irq_en) begin
      r[30] = 1'b0;
      r[31] = 1'b0;
    end
    return r;
  endfunction

  // accepted edge: groups whose edge code matches dir capture data
  task automatic model_cap(input logic dir, input logic [PW-1:0] d);
    for (int g = 0; g < NG; g++)
      if (grp_edge[g] == dir) hold_m[g] = d[g*GW +: GW];
  endtask

  function automatic logic [PW-1:0] mkport(input logic [PW-1:0] d, input logic req, input logic gate);
    logic [PW-1:0] r = d;
    r[30] = req;
    r[31] = gate;
    return r;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [PW-1:0] d;
    logic exp_p;
    int vi;
    for (int g = 0; g < NG; g++) hold_m[g] = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 pend", {31'b0, pend}, '0);
    chk("R1 irq", {31'b0, irq}, '0);
    lat_en = '1;
    port_in = 32'hA5C3_3C5A;
    wait_n(1);
    chk("R1 held zero", port_out, '0);

    // R2 disabled: transitions ignored, pins 30/31 visible
    lat_en = '1;
    irq_both = 1'b1;
    grp_edge = 4'b0101;
    for (int i = 0; i < 4; i++) begin
      port_in = mkport(32'h1111_1111 * (i + 1), i[0], 1'b0);
      wait_n(4);
      chk("R2 pend off", {31'b0, pend}, '0);
      chk("R2 no capture", port_out, exp_port());
    end
    lat_en = '0;
    port_in = mkport(32'h0, 1'b1, 1'b1);
    wait_n(1);
    chk("R2 pins visible", port_out, port_in);

    // sweep: R3 R4 R5 R6 R7 R8 R11
    irq_en = 1'b1;
    vi = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int both = 0; both < 2; both++)
        for (int dir = 0; dir < 2; dir++)
          for (int gt = 0; gt < 2; gt++)
            for (int ge = 0; ge < 16; ge++) begin
              vi++;
              irq_edge = pol[0];
              irq_both = both[0];
              grp_edge = ge[3:0];
              lat_en = ge[0] ? 4'hA : 4'hF;
              d = 32'(vi) * 32'h9E37_79B1;
              port_in = mkport(d, dir[0], 1'b1);
              wait_n(4);
              port_in = mkport(d, dir[0], gt[0]);
              wait_n(4);
              pend_clr = 1'b1;
              wait_n(1);
              pend_clr = 1'b0;
              wait_n(1);
              chk("R9 cleared", {31'b0, pend}, '0);
              d = ~d ^ 32'(vi * 7);
              port_in = mkport(d, ~dir[0], gt[0]);
              exp_p = (gt == 0) && ((both == 1) || (pol == dir));
              if (gt == 0) model_cap(dir[0], port_in);
              wait_n(3);
              chk((both == 1) ? "R6 pend" : (gt == 1) ? "R4 pend" : "R5 R7 pend",
                  {31'b0, pend}, {31'b0, exp_p});
              chk("R7 irq eq pend", {31'b0, irq}, {31'b0, pend});
              chk((gt == 1) ? "R4 R11 port" : "R3 R11 port", port_out, exp_port());
              if (exp_p) begin
                port_in = mkport(d ^ 32'h00FF_FF00, dir[0], 1'b0);
                wait_n(4);
                chk("R8 sticky", {31'b0, pend}, 32'd1);
                chk("R8 dropped", port_out, exp_port());
              end
            end

    // R9 collision: clear on the same edge as a new transition
    irq_both = 1'b1;
    lat_en = '1;
    grp_edge = 4'b0011;
    port_in = mkport(32'h0, 1'b0, 1'b1);
    wait_n(4);
    port_in = mkport(32'h0, 1'b0, 1'b0);
    wait_n(4);
    pend_clr = 1'b1;
    wait_n(1);
    pend_clr = 1'b0;
    port_in = mkport(32'h1234_5678, 1'b1, 1'b0);
    model_cap(1'b0, port_in);
    wait_n(3);
    chk("R7 pend set", {31'b0, pend}, 32'd1);
    port_in = mkport(32'h8765_4321, 1'b0, 1'b0);
    wait_n(2);
    pend_clr = 1'b1;
    wait_n(1);
    pend_clr = 1'b0;
    chk("R9 edge wins", {31'b0, pend}, 32'd1);
    chk("R8 no capture", port_out, exp_port());
    wait_n(2);
    pend_clr = 1'b1;
    wait_n(1);
    pend_clr = 1'b0;
    chk("R9 plain clear", {31'b0, pend}, '0);
    chk("R9 irq low", {31'b0, irq}, '0);

    // R10 disable clears
    port_in = mkport(32'h0F0F_0F0F, 1'b1, 1'b0);
    model_cap(1'b0, port_in);
    wait_n(3);
    chk("R10 pend set", {31'b0, pend}, 32'd1);
    irq_en = 1'b0;
    wait_n(1);
    chk("R10 pend cleared", {31'b0, pend}, '0);
    chk("R10 irq cleared", {31'b0, irq}, '0);
    lat_en = '0;
    wait_n(1);
    chk("R2 pins back", port_out, port_in);

    finish_run();
  end
endmodule